// File: doc/BRIEF.md
# JTAG Programming-Entry Data Registers

This block holds two test data registers that sit behind a JTAG TAP controller and control whether a device may enter its programming mode. A one-bit reset register sends a reset request to the device for as long as it holds a one. It has no update stage, so the request changes on the same TCK edge that shifts the bit in. A sixteen-bit unlock register has a shift stage and an update stage. Programming is enabled only while the update stage holds the fixed signature 16'hA370.

The TAP controller supplies the Capture-DR, Shift-DR and Update-DR strobes and one select line per register. Data enters on TDI with the least significant bit first. TDO presents the LSB of the selected register and changes on the falling edge of TCK. When neither register is selected, a one-bit bypass stage feeds TDO. The reset request goes straight to the external time-out logic. A separate clear input drops the unlock state when programming mode is left.

Top module: `jtag_prog_entry_regs`

## Requirements
- R1: While `rst` is high at a rising TCK edge, every stage is cleared. After that edge `dev_reset_req` and `prog_enabled` are 0, and `tdo` is 0 after the next falling edge.
- R2: When `sel_reset` and `shift_dr` are both high at a rising edge, the reset stage takes `tdi`. `dev_reset_req` shows the new value right after that edge, with no Update-DR needed.
- R3: The reset stage changes at no other time. Capture-DR, Update-DR and deselection leave `dev_reset_req` unchanged, so a one keeps reset requested.
- R4: When `sel_penable` is high (and `sel_reset` low) with `shift_dr`, the 16-bit shift stage moves one place toward bit 0 and `tdi` enters bit 15. After 16 shifts, the first bit shifted in sits in bit 0.
- R5: When the unlock register is selected with `update_dr`, the shift stage is copied into the update stage. `prog_enabled` becomes 1 after that edge only if the copied value is 16'hA370, and 0 otherwise. Shifting alone never changes `prog_enabled`.
- R6: When the unlock register is selected with `capture_dr`, the update stage is loaded into the shift stage so it can be read back on TDO. Capture takes priority over shift.
- R7: `clr_penable` high at a rising edge clears the update stage and `prog_enabled`. It overrides an Update-DR in the same cycle.
- R8: With neither select high, both shift stages hold their values. The bypass stage takes `tdi` on Shift-DR and is cleared on Capture-DR.
- R9: On each falling edge of TCK, `tdo` loads bit 0 of the selected register. The reset stage wins if `sel_reset` is high, then the unlock shift stage if `sel_penable` is high, and otherwise the bypass stage is used.
- R10: With both selects high, only the reset register is active. The unlock register neither shifts, captures nor updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tdi | input | 1 | Serial data in |
| capture_dr | input | 1 | TAP Capture-DR strobe |
| shift_dr | input | 1 | TAP Shift-DR strobe |
| update_dr | input | 1 | TAP Update-DR strobe |
| sel_reset | input | 1 | Instruction selects the reset register |
| sel_penable | input | 1 | Instruction selects the unlock register |
| clr_penable | input | 1 | Clear the unlock state on leaving programming mode |
| tdo | output | 1 | Serial data out, falling-edge timed |
| dev_reset_req | output | 1 | Raw device reset request |
| prog_enabled | output | 1 | Update stage equals the signature |

## Verification
Two functions can fall on the same rising edge: an Update-DR that would latch the signature, and `clr_penable` clearing the unlock state. A directed case shifts in 16'hA370 and then raises `update_dr` and `clr_penable` together. `prog_enabled` must stay 0, and a later update alone must set it. The random phase also raises the clear at random alongside update strobes, and a bench model in which the clear wins judges each cycle.

// File: rtl/jpe_pkg.sv
package jpe_pkg;
  localparam int unsigned UNLOCK_WIDTH = 16;
  localparam logic [UNLOCK_WIDTH-1:0] UNLOCK_SIGNATURE = 16'hA370;

  typedef enum logic [1:0] {
    DR_BYPASS = 2'd0,
    DR_RESET  = 2'd1,
    DR_UNLOCK = 2'd2
  } dr_sel_e;
endpackage

// File: rtl/jpe_select.sv
module jpe_select
  import jpe_pkg::*;
(
  input  logic    sel_reset,
  input  logic    sel_penable,
  output dr_sel_e active_dr
);
  // reset register has priority when both instructions are asserted
  always_comb begin
    if (sel_reset)        active_dr = DR_RESET;
    else if (sel_penable) active_dr = DR_UNLOCK;
    else                  active_dr = DR_BYPASS;
  end
endmodule

// File: rtl/jpe_reset_dr.sv
module jpe_reset_dr (
  input  logic tck,
  input  logic rst,
  input  logic tdi,
  input  logic active,
  input  logic shift_dr,
  output logic req
);
  // single stage, no update latch: the request follows the shift stage
  always_ff @(posedge tck) begin
    if (rst)                      req <= 1'b0;
    else if (active && shift_dr)  req <= tdi;
  end
endmodule

// File: rtl/jpe_unlock_dr.sv
module jpe_unlock_dr #(
  parameter int unsigned               WIDTH     = 16,
  parameter logic [WIDTH-1:0]          SIGNATURE = '0
) (
  input  logic tck,
  input  logic rst,
  input  logic tdi,
  input  logic active,
  input  logic capture_dr,
  input  logic shift_dr,
  input  logic update_dr,
  input  logic clr,
  output logic shift_lsb,
  output logic enabled
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [MSB:0] shift_q;
  logic [MSB:0] hold_q;

  always_ff @(posedge tck) begin
    if (rst) begin
      shift_q <= '0;
    end else if (active) begin
      if (capture_dr)    shift_q <= hold_q;
      else if (shift_dr) shift_q <= {tdi, shift_q[MSB:1]};
    end
  end

  // compare result registered alongside the update stage
  always_ff @(posedge tck) begin
    if (rst || clr) begin
      hold_q  <= '0;
      enabled <= 1'b0;
    end else if (active && update_dr) begin
      hold_q  <= shift_q;
      enabled <= (shift_q == SIGNATURE);
    end
  end

  assign shift_lsb = shift_q[0];
endmodule

// File: rtl/jpe_tdo_mux.sv
module jpe_tdo_mux
  import jpe_pkg::*;
(
  input  logic    tck,
  input  logic    rst,
  input  logic    tdi,
  input  logic    capture_dr,
  input  logic    shift_dr,
  input  dr_sel_e active_dr,
  input  logic    reset_lsb,
  input  logic    unlock_lsb,
  output logic    tdo
);
  logic bypass_q;
  logic tdo_d;

  always_ff @(posedge tck) begin
    if (rst)                              bypass_q <= 1'b0;
    else if (active_dr == DR_BYPASS) begin
      if (capture_dr)     bypass_q <= 1'b0;
      else if (shift_dr)  bypass_q <= tdi;
    end
  end

  always_comb begin
    unique case (active_dr)
      DR_RESET:  tdo_d = reset_lsb;
      DR_UNLOCK: tdo_d = unlock_lsb;
      default:   tdo_d = bypass_q;
    endcase
  end

  always_ff @(negedge tck) begin
    if (rst) tdo <= 1'b0;
    else     tdo <= tdo_d;
  end
endmodule

// File: rtl/jtag_prog_entry_regs.sv
module jtag_prog_entry_regs
  import jpe_pkg::*;
#(
  parameter int unsigned            WIDTH     = UNLOCK_WIDTH,
  parameter logic [WIDTH-1:0]       SIGNATURE = UNLOCK_SIGNATURE
) (
  input  logic tck,
  input  logic rst,
  input  logic tdi,
  input  logic capture_dr,
  input  logic shift_dr,
  input  logic update_dr,
  input  logic sel_reset,
  input  logic sel_penable,
  input  logic clr_penable,
  output logic tdo,
  output logic dev_reset_req,
  output logic prog_enabled
);
  dr_sel_e active_dr;
  logic    unlock_lsb;

  jpe_select u_select (
    .sel_reset   (sel_reset),
    .sel_penable (sel_penable),
    .active_dr   (active_dr)
  );

  jpe_reset_dr u_reset_dr (
    .tck      (tck),
    .rst      (rst),
    .tdi      (tdi),
    .active   (active_dr == DR_RESET),
    .shift_dr (shift_dr),
    .req      (dev_reset_req)
  );

  jpe_unlock_dr #(
    .WIDTH     (WIDTH),
    .SIGNATURE (SIGNATURE)
  ) u_unlock_dr (
    .tck        (tck),
    .rst        (rst),
    .tdi        (tdi),
    .active     (active_dr == DR_UNLOCK),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .update_dr  (update_dr),
    .clr        (clr_penable),
    .shift_lsb  (unlock_lsb),
    .enabled    (prog_enabled)
  );

  jpe_tdo_mux u_tdo_mux (
    .tck        (tck),
    .rst        (rst),
    .tdi        (tdi),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .active_dr  (active_dr),
    .reset_lsb  (dev_reset_req),
    .unlock_lsb (unlock_lsb),
    .tdo        (tdo)
  );
endmodule

// File: rtl/jpe_checker.sv
module jpe_checker (
  input logic tck,
  input logic rst,
  input logic tdi,
  input logic shift_dr,
  input logic update_dr,
  input logic sel_reset,
  input logic sel_penable,
  input logic clr_penable,
  input logic dev_reset_req,
  input logic prog_enabled
);
  assert_reset_clears_R1: assert property (@(posedge tck)
    rst |=> (!dev_reset_req && !prog_enabled));

  assert_req_follows_shift_R2: assert property (@(posedge tck) disable iff (rst)
    (sel_reset && shift_dr) |=> (dev_reset_req == $past(tdi)));

  assert_req_holds_R3: assert property (@(posedge tck) disable iff (rst)
    !(sel_reset && shift_dr) |=> $stable(dev_reset_req));

  assert_enable_needs_update_R5: assert property (@(posedge tck) disable iff (rst)
    $rose(prog_enabled) |-> $past(update_dr && sel_penable && !sel_reset && !clr_penable));

  assert_clear_wins_R7: assert property (@(posedge tck) disable iff (rst)
    clr_penable |=> !prog_enabled);

  assert_both_selected_R10: assert property (@(posedge tck) disable iff (rst)
    (sel_reset && sel_penable) |=> !$rose(prog_enabled));
endmodule

bind jtag_prog_entry_regs jpe_checker i_jpe_checker (
  .tck           (tck),
  .rst           (rst),
  .tdi           (tdi),
  .shift_dr      (shift_dr),
  .update_dr     (update_dr),
  .sel_reset     (sel_reset),
  .sel_penable   (sel_penable),
  .clr_penable   (clr_penable),
  .dev_reset_req (dev_reset_req),
  .prog_enabled  (prog_enabled)
);

// File: tb/test_jtag_prog_entry_regs.sv
module test_jtag_prog_entry_regs;
  localparam logic [15:0] SIG = 16'hA370;

  logic tck = 1'b0;
  logic rst = 1'b1;
  logic tdi = 1'b0, cap = 1'b0, sh = 1'b0, upd = 1'b0;
  logic sel_r = 1'b0, sel_p = 1'b0, clr = 1'b0;
  logic tdo, dev_reset_req, prog_enabled;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state
  logic        m_rst = 1'b0, m_en = 1'b0, m_byp = 1'b0;
  logic [15:0] m_sr = '0, m_upd = '0;

  always #4 tck = ~tck;

  jtag_prog_entry_regs i_jtag_prog_entry_regs (
    .tck(tck), .rst(rst), .tdi(tdi), .capture_dr(cap), .shift_dr(sh),
    .update_dr(upd), .sel_reset(sel_r), .sel_penable(sel_p),
    .clr_penable(clr), .tdo(tdo), .dev_reset_req(dev_reset_req),
    .prog_enabled(prog_enabled)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // one TCK cycle: model update, then output checks
  task automatic tick();
    logic        nr = m_rst, ne = m_en, nb = m_byp;
    logic [15:0] ns = m_sr, nu = m_upd;
    if (rst) begin
      nr = 0; ne = 0; nb = 0; ns = '0; nu = '0;
    end else begin
      if (sel_r) begin
        if (sh) nr = tdi;
      end else if (sel_p) begin
        if (cap) ns = m_upd;
        else if (sh) ns = {tdi, m_sr[15:1]};
      end else begin
        if (cap) nb = 1'b0;
        else if (sh) nb = tdi;
      end
      if (clr) begin nu = '0; ne = 1'b0; end
      else if (sel_p && !sel_r && upd) begin nu = m_sr; ne = (m_sr == SIG); end
    end
    @(posedge tck); #1;
    m_rst = nr; m_en = ne; m_byp = nb; m_sr = ns; m_upd = nu;
    check("R2/R3 dev_reset_req", dev_reset_req, m_rst);
    check("R5/R7 prog_enabled", prog_enabled, m_en);
    @(negedge tck); #1;
    check("R9 tdo", tdo, rst ? 1'b0 : sel_r ? m_rst : sel_p ? m_sr[0] : m_byp);
  endtask

  task automatic idle();
    cap = 0; sh = 0; upd = 0; clr = 0;
  endtask

  task automatic shift_word(logic [15:0] w);
    idle(); sh = 1;
    for (int i = 0; i < 16; i++) begin tdi = w[i]; tick(); end
    idle();
  endtask

  task automatic pulse_update();
    idle(); upd = 1; tick(); idle();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    void'($urandom(32'd4242));
    // R1 reset state
    rst = 1; tick(); tick();
    check("R1 dev_reset_req", dev_reset_req, 1'b0);
    check("R1 prog_enabled", prog_enabled, 1'b0);
    check("R1 tdo", tdo, 1'b0);
    rst = 0;

    // R2 / R3: unlatched reset request
    sel_r = 1; idle(); sh = 1; tdi = 1; tick();
    check("R2 req immediate", dev_reset_req, 1'b1);
    idle(); upd = 1; tdi = 0; tick();
    check("R3 update keeps req", dev_reset_req, 1'b1);
    idle(); cap = 1; tick();
    check("R3 capture keeps req", dev_reset_req, 1'b1);
    idle(); sel_r = 0; sh = 1; tick();
    check("R3 deselect keeps req", dev_reset_req, 1'b1);
    sel_r = 1; sh = 1; tdi = 0; tick();
    check("R2 req cleared", dev_reset_req, 1'b0);
    sel_r = 0; idle();

    // R4: LSB-first shift read back on tdo
    sel_p = 1; w = 16'h5A3C; shift_word(w);
    sh = 1;
    for (int i = 0; i < 16; i++) begin
      check("R4 shifted bit order", tdo, w[i]);
      tdi = 0; tick();
    end
    idle();

    // R5: signature unlocks only after update
    shift_word(SIG);
    check("R5 no enable before update", prog_enabled, 1'b0);
    pulse_update();
    check("R5 enable after update", prog_enabled, 1'b1);
    shift_word(16'h1234);
    check("R5 shifting keeps enable", prog_enabled, 1'b1);
    pulse_update();
    check("R5 mismatch disables", prog_enabled, 1'b0);
    shift_word(16'hA371); pulse_update();
    check("R5 near miss rejected", prog_enabled, 1'b0);

    // R6: capture readback of update stage
    shift_word(SIG); pulse_update(); shift_word(16'h0000);
    idle(); cap = 1; tick(); idle(); sh = 1;
    for (int i = 0; i < 16; i++) begin
      check("R6 capture readback", tdo, SIG[i]);
      tdi = 0; tick();
    end
    idle();

    // R7: clear wins over same-cycle update
    shift_word(SIG);
    idle(); upd = 1; clr = 1; tick(); idle();
    check("R7 clear beats update", prog_enabled, 1'b0);
    pulse_update();
    check("R7 later update enables", prog_enabled, 1'b1);
    idle(); clr = 1; tick(); idle();
    check("R7 clear alone", prog_enabled, 1'b0);

    // R8: deselected stages hold, bypass carries tdi
    w = 16'hC0DE; shift_word(w);
    sel_p = 0; sh = 1;
    for (int i = 0; i < 10; i++) begin
      tdi = logic'($urandom_range(1)); tick();
      check("R8 bypass follows tdi", tdo, tdi);
    end
    idle(); cap = 1; tick(); idle();
    check("R8 bypass capture zero", tdo, 1'b0);
    sel_p = 1; sh = 1;
    for (int i = 0; i < 16; i++) begin
      check("R8 unlock stage held", tdo, w[i]);
      tdi = 0; tick();
    end
    idle();

    // R10: both selected, unlock register inactive
    sel_r = 1; sel_p = 1; shift_word(SIG); pulse_update();
    check("R10 no unlock when both selected", prog_enabled, 1'b0);
    check("R10 reset stage took last bit", dev_reset_req, SIG[15]);
    sel_r = 0; sh = 1; tdi = 0; tick(); idle();
    sel_r = 1; sh = 1; tdi = 0; tick(); idle(); sel_r = 0;

    // random phase, model-checked every cycle
    for (int n = 0; n < 3000; n++) begin
      int s;
      if (n % 250 == 0) begin
        sel_r = 0; sel_p = 1; shift_word(SIG);
      end
      s = $urandom_range(7);
      sel_r = (s == 1) || (s == 7);
      sel_p = (s >= 2);
      idle();
      case ($urandom_range(3))
        0: cap = 1;
        1: sh = 1;
        2: upd = 1;
        default: ;
      endcase
      tdi = logic'($urandom_range(1));
      clr = ($urandom_range(15) == 0);
      tick();
    end
    idle(); sel_r = 0; sel_p = 0;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule